// File: doc/BRIEF.md
# Four-Level Core Power State Controller

This block moves a processor core between four power levels: full run, doze, nap and sleep. Software arms a low-power entry by writing a control word that holds a wait-enable bit and a mode field. The controller then runs the handshakes with the core. It raises a halt request and waits for its acknowledge to reach doze, where fetch and execution stop but the core clock keeps running. For a deeper level it then raises a stop request and waits for that acknowledge. After that it drops the core clock enable (nap), or both the core clock enable and the timebase clock enable (sleep).

A wake input from external logic brings the block back to full run from doze, nap or sleep. The exit runs in a fixed order: timebase clock first, then core clock together with release of stop, then release of halt. The wait-enable bit clears on wake, so the core stays in full run until software arms it again. The outputs are enables and request levels only. Real clock gating cells and voltage control sit outside the block.

Control word layout: bit 0 is wait-enable. Bits [MODE_W:1] hold the mode code: 0 selects doze, 1 selects nap, 2 selects sleep, and any other value acts as doze.

Top module: `pwr_level_ctrl`

## Requirements
- R1: After reset the outputs are halt_req=0, stop_req=0, core_clk_en=1, tb_clk_en=1 (full run).
- R2: A write with bit 0 set is registered on the write edge, and halt_req rises one clock later. Both clock enables stay 1 and stop_req stays 0.
- R3: While halt_ack has not been seen, stop_req stays 0 and the clocks stay on. After halt_ack the block holds halt_req in doze, and in doze mode it never raises stop_req.
- R4: With mode 1 (nap), stop_req rises one clock after doze is reached. One clock after stop_ack, core_clk_en drops to 0 while tb_clk_en stays 1.
- R5: With mode 2 (sleep), one clock after stop_ack both core_clk_en and tb_clk_en are 0, with halt_req and stop_req held at 1.
- R6: Mode codes other than 0, 1 and 2 behave as doze: stop_req never rises, even when stop_ack is driven.
- R7: A wake in sleep gives, on successive clocks: tb_clk_en=1 with the core clock still off; then core_clk_en=1 and stop_req=0; then halt_req=0.
- R8: A wake in nap gives core_clk_en=1 and stop_req=0 one clock later, and halt_req=0 the clock after that.
- R9: A wake in doze drops halt_req one clock later.
- R10: A wake clears wait-enable, so after an exit the block stays in full run until a new write.
- R11: Wake is ignored while the block waits for halt_ack or stop_ack: the handshake continues as if wake were low.
- R12: stop_req is never 1 without halt_req. The core clock is never off without stop_req. The timebase clock is never off while the core clock is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | MODE_W+1 | Control word: bit 0 wait-enable, upper bits mode |
| halt_ack | input | 1 | Core confirms fetch and execution are halted |
| stop_ack | input | 1 | Core confirms it is ready for clock stop |
| wake | input | 1 | Wake-up request from external logic |
| halt_req | output | 1 | Halt request to the core |
| stop_req | output | 1 | Stop request to the core |
| core_clk_en | output | 1 | Enable for the core clock domain |
| tb_clk_en | output | 1 | Enable for the timebase clock domain |

## Verification
Directed passes arm each mode in turn: doze, nap, sleep and an undefined code. These runs separate the three depths by which enables fall, and they show that an undefined code cannot reach a stop. Each pass also withholds an acknowledge for some clocks and raises wake during the waits, which shows whether the handshake can be skipped or cut short. Exits from each level are checked clock by clock, so an exit order with the wrong sequence or the wrong length shows up. Long random runs of writes, acknowledges and wakes then compare all four outputs every clock against a bench model, which exposes races such as a write and a wake on the same edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN,
        PS_HALT_WT,
        PS_DOZE,
        PS_STOP_WT,
        PS_NAP,
        PS_SLEEP,
        PS_WK_TB,
        PS_WK_CORE
    } pwr_state_e;

    typedef enum logic [1:0] {
        TGT_DOZE,
        TGT_NAP,
        TGT_SLEEP
    } pwr_tgt_e;

    typedef struct packed {
        logic halt;
        logic stop;
        logic core_en;
        logic tb_en;
    } pwr_out_t;

endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg #(
    parameter int MODE_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [MODE_W:0]             wdata,
    input  logic                        wake_clr,
    output logic                        wait_en,
    output pwr_pkg::pwr_tgt_e           tgt
);
    import pwr_pkg::*;

    localparam logic [MODE_W-1:0] NAP_CODE   = MODE_W'(1);
    localparam logic [MODE_W-1:0] SLEEP_CODE = MODE_W'(2);

    typedef struct packed {
        logic              wait_en;
        logic [MODE_W-1:0] mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.wait_en = wdata[0];
            ctl_d.mode    = wdata[MODE_W:1];
        end
        // wake clear outranks a same-edge write of the enable bit
        if (wake_clr) begin
            ctl_d.wait_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (ctl_q.mode == NAP_CODE) begin
            tgt = TGT_NAP;
        end else if (ctl_q.mode == SLEEP_CODE) begin
            tgt = TGT_SLEEP;
        end else begin
            tgt = TGT_DOZE;
        end
    end

    assign wait_en = ctl_q.wait_en;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wait_en,
    input  pwr_pkg::pwr_tgt_e    tgt,
    input  logic                 halt_ack,
    input  logic                 stop_ack,
    input  logic                 wake,
    output pwr_pkg::pwr_state_e  state,
    output logic                 wake_clr
);
    import pwr_pkg::*;

    typedef struct packed {
        pwr_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        wake_clr = 1'b0;
        unique case (seq_q.st)
            PS_RUN: begin
                if (wait_en) seq_d.st = PS_HALT_WT;
            end
            PS_HALT_WT: begin
                if (halt_ack) seq_d.st = PS_DOZE;
            end
            PS_DOZE: begin
                if (wake) begin
                    seq_d.st = PS_RUN;
                    wake_clr = 1'b1;
                end else if (tgt != TGT_DOZE) begin
                    seq_d.st = PS_STOP_WT;
                end
            end
            PS_STOP_WT: begin
                if (stop_ack) seq_d.st = (tgt == TGT_SLEEP) ? PS_SLEEP : PS_NAP;
            end
            PS_NAP: begin
                if (wake) begin
                    seq_d.st = PS_WK_CORE;
                    wake_clr = 1'b1;
                end
            end
            PS_SLEEP: begin
                if (wake) begin
                    seq_d.st = PS_WK_TB;
                    wake_clr = 1'b1;
                end
            end
            PS_WK_TB:   seq_d.st = PS_WK_CORE;
            PS_WK_CORE: seq_d.st = PS_RUN;
            default:    seq_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: PS_RUN};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;

endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec (
    input  pwr_pkg::pwr_state_e state,
    output pwr_pkg::pwr_out_t   outs
);
    import pwr_pkg::*;

    always_comb begin
        unique case (state)
            PS_RUN:     outs = '{halt: 1'b0, stop: 1'b0, core_en: 1'b1, tb_en: 1'b1};
            PS_HALT_WT: outs = '{halt: 1'b1, stop: 1'b0, core_en: 1'b1, tb_en: 1'b1};
            PS_DOZE:    outs = '{halt: 1'b1, stop: 1'b0, core_en: 1'b1, tb_en: 1'b1};
            PS_STOP_WT: outs = '{halt: 1'b1, stop: 1'b1, core_en: 1'b1, tb_en: 1'b1};
            PS_NAP:     outs = '{halt: 1'b1, stop: 1'b1, core_en: 1'b0, tb_en: 1'b1};
            PS_SLEEP:   outs = '{halt: 1'b1, stop: 1'b1, core_en: 1'b0, tb_en: 1'b0};
            PS_WK_TB:   outs = '{halt: 1'b1, stop: 1'b1, core_en: 1'b0, tb_en: 1'b1};
            PS_WK_CORE: outs = '{halt: 1'b1, stop: 1'b0, core_en: 1'b1, tb_en: 1'b1};
            default:    outs = '{halt: 1'b0, stop: 1'b0, core_en: 1'b1, tb_en: 1'b1};
        endcase
    end

endmodule

// File: rtl/pwr_level_ctrl.sv
module pwr_level_ctrl #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [MODE_W:0]   ctl_wdata,
    input  logic              halt_ack,
    input  logic              stop_ack,
    input  logic              wake,
    output logic              halt_req,
    output logic              stop_req,
    output logic              core_clk_en,
    output logic              tb_clk_en
);
    import pwr_pkg::*;

    logic       wait_en;
    logic       wake_clr;
    pwr_tgt_e   tgt;
    pwr_state_e state;
    pwr_out_t   outs;

    pwr_ctrl_reg #(.MODE_W(MODE_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .wake_clr (wake_clr),
        .wait_en  (wait_en),
        .tgt      (tgt)
    );

    pwr_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_en  (wait_en),
        .tgt      (tgt),
        .halt_ack (halt_ack),
        .stop_ack (stop_ack),
        .wake     (wake),
        .state    (state),
        .wake_clr (wake_clr)
    );

    pwr_out_dec u_dec (
        .state (state),
        .outs  (outs)
    );

    assign halt_req    = outs.halt;
    assign stop_req    = outs.stop;
    assign core_clk_en = outs.core_en;
    assign tb_clk_en   = outs.tb_en;

endmodule

// File: rtl/pwr_level_chk.sv
module pwr_level_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_ack,
    input logic stop_ack,
    input logic wake,
    input logic halt_req,
    input logic stop_req,
    input logic core_clk_en,
    input logic tb_clk_en
);

    // R12: stop only while halt is held
    a_r12_stop_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> halt_req);

    // R12: core clock off only with stop asserted
    a_r12_core_off_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> stop_req);

    // R5: timebase off implies core off
    a_r5_tb_off_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_clk_en |-> !core_clk_en);

    // R3: stop rises only after halt was already held
    a_r3_stop_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(halt_req));

    // R4: core clock drops only on an accepted stop acknowledge
    a_r4_core_off_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(stop_ack));

    // R7: core clock returns only with the timebase running
    a_r7_core_after_tb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> tb_clk_en && !stop_req);

    // R9: halt releases last, with both clocks on
    a_r9_halt_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_req) |-> core_clk_en && tb_clk_en && !stop_req);

    // R2: halt rises with clocks running and no stop
    a_r2_halt_rise_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> core_clk_en && tb_clk_en && !stop_req);

    // R11: wake never leaves the halt wait without its acknowledge
    a_r11_halt_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !stop_req && !halt_ack && $past(halt_req) && !$past(stop_req)
         && $past(core_clk_en)) |=> halt_req || $past(wake));

endmodule

bind pwr_level_ctrl pwr_level_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_ack    (halt_ack),
    .stop_ack    (stop_ack),
    .wake        (wake),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .core_clk_en (core_clk_en),
    .tb_clk_en   (tb_clk_en)
);

// File: tb/sim_pwr_level_ctrl.sv
module sim_pwr_level_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MODE_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [MODE_W:0]   ctl_wdata = '0;
    logic              halt_ack = 1'b0;
    logic              stop_ack = 1'b0;
    logic              wake = 1'b0;
    logic              halt_req, stop_req, core_clk_en, tb_clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state: 0 run,1 halt wait,2 doze,3 stop wait,4 nap,5 sleep,6 wake tb,7 wake core
    int       m_st = 0;
    bit       m_en = 1'b0;
    bit [1:0] m_md = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_level_ctrl #(.MODE_W(MODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .halt_ack(halt_ack), .stop_ack(stop_ack), .wake(wake),
        .halt_req(halt_req), .stop_req(stop_req),
        .core_clk_en(core_clk_en), .tb_clk_en(tb_clk_en)
    );

    function automatic bit [3:0] exp_of(int st);
        case (st)
            0: return 4'b0011;
            1, 2, 7: return 4'b1011;
            3: return 4'b1111;
            4, 6: return 4'b1101;
            5: return 4'b1100;
            default: return 4'b0011;
        endcase
    endfunction

    task automatic model_step(bit we, bit [2:0] wd, bit ha, bit sa, bit wk);
        bit clr = 1'b0;
        int nx  = m_st;
        int tg  = (m_md == 2'd1) ? 1 : (m_md == 2'd2) ? 2 : 0;
        case (m_st)
            0: if (m_en) nx = 1;
            1: if (ha) nx = 2;
            2: if (wk) begin nx = 0; clr = 1'b1; end else if (tg != 0) nx = 3;
            3: if (sa) nx = (tg == 2) ? 5 : 4;
            4: if (wk) begin nx = 7; clr = 1'b1; end
            5: if (wk) begin nx = 6; clr = 1'b1; end
            6: nx = 7;
            default: nx = 0;
        endcase
        if (we) begin m_en = wd[0]; m_md = wd[2:1]; end
        if (clr) m_en = 1'b0;
        m_st = nx;
    endtask

    task automatic check(string req, bit [3:0] exp);
        bit [3:0] act = {halt_req, stop_req, core_clk_en, tb_clk_en};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {halt,stop,core,tb} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive after a falling edge, let one rising edge pass, check at next falling edge
    task automatic cyc(bit we, bit [2:0] wd, bit ha, bit sa, bit wk, string req, bit [3:0] exp);
        ctl_we = we; ctl_wdata = wd; halt_ack = ha; stop_ack = sa; wake = wk;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic idle(int n, string req, bit [3:0] exp);
        for (int i = 0; i < n; i++) cyc(0, 3'b000, 0, 0, 0, req, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ctl_we = 0; ctl_wdata = '0; halt_ack = 0; stop_ack = 0; wake = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_st = 0; m_en = 1'b0; m_md = 2'd0;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a_5e0d));
        do_reset();
        check("R1 reset state", 4'b0011);

        // doze
        cyc(1, 3'b001, 0, 0, 0, "R2 write registered", 4'b0011);
        cyc(0, 3'b000, 0, 0, 0, "R2 halt raised", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R3 waiting for halt ack", 4'b1011);
        cyc(0, 3'b000, 0, 0, 1, "R11 wake ignored in halt wait", 4'b1011);
        cyc(0, 3'b000, 1, 0, 0, "R3 doze entered", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R3 no stop in doze mode", 4'b1011);
        cyc(0, 3'b000, 0, 0, 1, "R9 wake from doze", 4'b0011);
        idle(5, "R10 stays in run after doze exit", 4'b0011);

        // nap
        cyc(1, 3'b011, 0, 0, 0, "R2 nap write", 4'b0011);
        cyc(0, 3'b000, 0, 0, 0, "R2 halt raised", 4'b1011);
        cyc(0, 3'b000, 1, 0, 0, "R4 doze before nap", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R4 stop raised", 4'b1111);
        cyc(0, 3'b000, 0, 0, 1, "R11 wake ignored in stop wait", 4'b1111);
        cyc(0, 3'b000, 0, 1, 0, "R4 nap core off", 4'b1101);
        cyc(0, 3'b000, 0, 0, 0, "R4 nap holds", 4'b1101);
        cyc(0, 3'b000, 0, 0, 1, "R8 core back and stop off", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R8 halt off", 4'b0011);
        idle(3, "R10 stays in run after nap exit", 4'b0011);

        // sleep
        cyc(1, 3'b101, 0, 0, 0, "R2 sleep write", 4'b0011);
        cyc(0, 3'b000, 0, 0, 0, "R2 halt raised", 4'b1011);
        cyc(0, 3'b000, 1, 0, 0, "R5 doze before sleep", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R5 stop raised", 4'b1111);
        cyc(0, 3'b000, 0, 1, 0, "R5 both clocks off", 4'b1100);
        cyc(0, 3'b000, 0, 0, 0, "R5 sleep holds", 4'b1100);
        cyc(0, 3'b000, 0, 0, 1, "R7 timebase first", 4'b1101);
        cyc(0, 3'b000, 0, 0, 0, "R7 core and stop release", 4'b1011);
        cyc(0, 3'b000, 0, 0, 0, "R7 halt release", 4'b0011);
        idle(3, "R10 stays in run after sleep exit", 4'b0011);

        // undefined mode code 3 acts as doze
        cyc(1, 3'b111, 0, 0, 0, "R6 undefined write", 4'b0011);
        cyc(0, 3'b000, 0, 0, 0, "R6 halt raised", 4'b1011);
        cyc(0, 3'b000, 1, 0, 0, "R6 doze entered", 4'b1011);
        for (int i = 0; i < 3; i++) cyc(0, 3'b000, 0, 1, 0, "R6 no stop with undefined mode", 4'b1011);
        cyc(0, 3'b000, 0, 0, 1, "R6 wake from doze", 4'b0011);

        // random mix against the bench model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit       we = ($urandom % 10) == 0;
            bit [2:0] wd = 3'($urandom);
            bit       ha = ($urandom % 3) == 0;
            bit       sa = ($urandom % 3) == 0;
            bit       wk = ($urandom % 7) == 0;
            if (($urandom % 4) == 0) wd[0] = 1'b1;
            model_step(we, wd, ha, sa, wk);
            cyc(we, wd, ha, sa, wk, "R12 random sequence vs model", exp_of(m_st));
            checks++;
            if ((stop_req && !halt_req) || (!core_clk_en && !stop_req) || (!tb_clk_en && core_clk_en)) begin
                fails++;
                $display("FAIL R12 invariant: actual=%b%b%b%b expected=ordered enables",
                         halt_req, stop_req, core_clk_en, tb_clk_en);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule